// File: doc/BRIEF.md
# Interconnect Intermittency Monitor

This block watches for cracked or momentarily open joints on a dedicated pair of bidirectional test pads. The two pads are tied together off-chip and share a small capacitor to ground. The block uses neither functional I/O nor host logic and runs alongside them. It works like a tiny memory test on that capacitor. One pad drives a single-cycle low pulse and then releases the net. The block reads the net back through the other pad. It then does the same with a single-cycle high pulse. A joint with high resistance cannot charge the capacitor past the logic-high threshold within one clock period. The read-back therefore misses the driven value, and the miss is logged as an intermittent event.

The two pads swap roles every half round. Pad 0 drives and pad 1 senses, then pad 1 drives and pad 0 senses. A miss is charged to the pad that was driving. For each pad the host sees a sticky failure flag, a live fault flag that tracks the most recent read, and a saturating event counter. The only controls are clock, enable and an active-low reset.

Top module: `intermit_mon`

## Requirements
- R1: Reset (rst_ni low) clears both sticky flags, both live flags and both counters, and holds both pad output enables low.
- R2: While en_i is low, both pad output enables are low, the sequence does not advance, and all flags and counters hold their values.
- R3: A round lasts 8 enabled cycles. Pad 0 drives in the first four and pad 1 in the last four. Within each half the order is: drive 0 for one cycle, release for one cycle, drive 1 for one cycle, release for one cycle. After reset the round starts with pad 0 driving 0.
- R4: At most one pad output enable is high in any cycle, and only the pad whose half it is drives.
- R5: The sense pad is sampled at the enabled clock edge that ends each release cycle. The sample goes through a two-flop synchroniser. The resulting flag and counter update appears at the second enabled edge after the sample.
- R6: A read-back that differs from the value driven in that half (a 1 read after a 0 write, or a 0 read after a 1 write) is a fault event for the driving pad. A matching read-back is a pass for the driving pad.
- R7: A pad's sticky flag (sticky_o bit 0 for pad 0, bit 1 for pad 1) sets on that pad's first fault event and clears only on reset.
- R8: A pad's live flag (live_o bit 0 for pad 0, bit 1 for pad 1) sets on a fault event for that pad and clears on the next pass for that pad.
- R9: Each fault event adds one to that pad's 8-bit counter. The counter saturates at 255 and does not wrap.
- R10: Fault events charged to one pad never change the other pad's flags or counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable; low freezes the monitor and releases the pads |
| tp0_o | output | 1 | Pad 0 drive value |
| tp0_oe_o | output | 1 | Pad 0 output enable |
| tp0_i | input | 1 | Pad 0 sensed level |
| tp1_o | output | 1 | Pad 1 drive value |
| tp1_oe_o | output | 1 | Pad 1 output enable |
| tp1_i | input | 1 | Pad 1 sensed level |
| sticky_o | output | 2 | Sticky failure flag per pad |
| live_o | output | 2 | Live fault flag per pad |
| cnt0_o | output | 8 | Saturating fault event count, pad 0 |
| cnt1_o | output | 8 | Saturating fault event count, pad 1 |

## Verification
The two functions that can meet in one cycle are the enable drop and the arrival of a synchronised read result that is still in flight. A result due on an edge where en_i is low must neither be lost nor applied early. A second collision is a fault event landing on a counter already at 255 while the live flag keeps toggling. The bench gates enable in irregular patterns while an open is injected. It also holds an open on pad 1 long enough to saturate that counter. A behavioural model of the capacitor net and the round ordering predicts every flag, counter and output enable, and the bench compares them with the design on every cycle.

// File: rtl/intermit_pkg.sv
package intermit_pkg;
  localparam int NUM_PADS = 2;

  // bit2: driving pad, bit1: level driven/expected, bit0: release (check) slot
  typedef enum logic [2:0] {
    PH_A_LO  = 3'd0,
    PH_A_CK0 = 3'd1,
    PH_A_HI  = 3'd2,
    PH_A_CK1 = 3'd3,
    PH_B_LO  = 3'd4,
    PH_B_CK0 = 3'd5,
    PH_B_HI  = 3'd6,
    PH_B_CK1 = 3'd7
  } phase_e;

  typedef struct packed {
    logic vld;
    logic pin;
    logic exp;
  } probe_t;
endpackage

// File: rtl/intermit_seq.sv
module intermit_seq
  import intermit_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  output logic [1:0] oe_o,
  output logic       val_o,
  output probe_t     probe_o
);
  phase_e ph_q;
  logic   drv_pin;
  logic   drv_slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ph_q <= PH_A_LO;
    else if (en_i) ph_q <= phase_e'(ph_q + 3'd1);
  end

  assign drv_pin  = ph_q[2];
  assign drv_slot = ~ph_q[0];

  // pads float during reset and while disabled
  assign oe_o[0] = rst_ni & en_i & drv_slot & ~drv_pin;
  assign oe_o[1] = rst_ni & en_i & drv_slot &  drv_pin;
  assign val_o   = ph_q[1];

  assign probe_o = '{vld: en_i & ph_q[0], pin: drv_pin, exp: ph_q[1]};

  // R3: round wraps back to pad 0 low pulse
  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_B_CK1 && en_i) |=> (ph_q == PH_A_LO));

  // R3: a drive pulse never lasts beyond one cycle
  p_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o != 2'b00) |=> (oe_o == 2'b00));
endmodule

// File: rtl/intermit_sync.sv
module intermit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sh_q <= '0;
    else if (en_i) sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/intermit_judge.sv
module intermit_judge
  import intermit_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  probe_t     probe_i,
  input  logic [1:0] sense_i,
  output logic [1:0] fault_o,
  output logic [1:0] pass_o
);
  probe_t pipe_q [STAGES];
  probe_t due;
  logic   seen;
  logic   hit;
  logic   miss;

  // probe delay matches synchroniser depth
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
    end else if (en_i) begin
      pipe_q[0] <= probe_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign due  = pipe_q[STAGES-1];
  assign seen = due.pin ? sense_i[0] : sense_i[1];
  assign hit  = en_i & due.vld;
  assign miss = seen ^ due.exp;

  always_comb begin
    fault_o = 2'b00;
    pass_o  = 2'b00;
    if (hit) begin
      fault_o[due.pin] = miss;
      pass_o[due.pin]  = ~miss;
    end
  end

  // R10: one event per result, charged to a single pad
  p_one_pad_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fault_o, pass_o}));
endmodule

// File: rtl/intermit_score.sv
module intermit_score #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             fault_i,
  input  logic             pass_i,
  output logic             sticky_o,
  output logic             live_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_o <= 1'b0;
      live_o   <= 1'b0;
      cnt_o    <= '0;
    end else if (en_i) begin
      if (fault_i) begin
        sticky_o <= 1'b1;
        live_o   <= 1'b1;
        if (cnt_o != CNT_MAX) cnt_o <= cnt_o + CNT_ONE;
      end else if (pass_i) begin
        live_o <= 1'b0;
      end
    end
  end

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sticky_o |=> sticky_o);

  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX));

  p_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o != $past(cnt_o)) |-> (cnt_o == $past(cnt_o) + CNT_ONE));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(cnt_o) && $stable(live_o) && $stable(sticky_o)));

  p_live_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_o |-> sticky_o);
endmodule

// File: rtl/intermit_mon.sv
module intermit_mon
  import intermit_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic             tp0_o,
  output logic             tp0_oe_o,
  input  logic             tp0_i,
  output logic             tp1_o,
  output logic             tp1_oe_o,
  input  logic             tp1_i,
  output logic [1:0]       sticky_o,
  output logic [1:0]       live_o,
  output logic [CNT_W-1:0] cnt0_o,
  output logic [CNT_W-1:0] cnt1_o
);
  logic [NUM_PADS-1:0] oe;
  logic                val;
  probe_t              probe;
  logic [NUM_PADS-1:0] pad_in;
  logic [NUM_PADS-1:0] pad_sync;
  logic [NUM_PADS-1:0] fault;
  logic [NUM_PADS-1:0] pass;
  logic [CNT_W-1:0]    cnt [NUM_PADS];

  intermit_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .oe_o    (oe),
    .val_o   (val),
    .probe_o (probe)
  );

  assign tp0_o    = val;
  assign tp1_o    = val;
  assign tp0_oe_o = oe[0];
  assign tp1_oe_o = oe[1];
  assign pad_in   = {tp1_i, tp0_i};

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    intermit_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .d_i    (pad_in[p]),
      .q_o    (pad_sync[p])
    );

    intermit_score #(.CNT_W(CNT_W)) u_score (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_i),
      .fault_i  (fault[p]),
      .pass_i   (pass[p]),
      .sticky_o (sticky_o[p]),
      .live_o   (live_o[p]),
      .cnt_o    (cnt[p])
    );
  end

  intermit_judge #(.STAGES(SYNC_STAGES)) u_judge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .probe_i (probe),
    .sense_i (pad_sync),
    .fault_o (fault),
    .pass_o  (pass)
  );

  assign cnt0_o = cnt[0];
  assign cnt1_o = cnt[1];

  // R4: pads never drive together
  p_single_driver_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tp0_oe_o && tp1_oe_o));

  // R2: released pads while disabled
  p_float_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!tp0_oe_o && !tp1_oe_o));
endmodule

// File: tb/sim_intermit_mon.sv
module sim_intermit_mon;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       tp0_o, tp0_oe, tp1_o, tp1_oe;
  logic       pnet = 1'b0;
  logic [1:0] sticky, live;
  logic [7:0] cnt0, cnt1;
  bit         open0 = 0, open1 = 0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  intermit_mon u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .tp0_o(tp0_o), .tp0_oe_o(tp0_oe), .tp0_i(pnet),
    .tp1_o(tp1_o), .tp1_oe_o(tp1_oe), .tp1_i(pnet),
    .sticky_o(sticky), .live_o(live), .cnt0_o(cnt0), .cnt1_o(cnt1)
  );

  // capacitor net: a driver through an open joint cannot move it
  always @(posedge clk) begin
    if (tp0_oe && !open0)      pnet <= tp0_o;
    else if (tp1_oe && !open1) pnet <= tp1_o;
  end

  // reference model
  int ph = 0;
  bit rnet = 0;
  int q_age[$];
  bit q_pin[$], q_exp[$], q_obs[$];
  bit r_sticky[2] = '{0, 0};
  bit r_live[2]   = '{0, 0};
  int r_cnt[2]    = '{0, 0};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0;
      q_age.delete(); q_pin.delete(); q_exp.delete(); q_obs.delete();
      for (int p = 0; p < 2; p++) begin
        r_sticky[p] = 0; r_live[p] = 0; r_cnt[p] = 0;
      end
    end else if (en) begin
      for (int i = 0; i < q_age.size(); i++) q_age[i]--;
      while (q_age.size() > 0 && q_age[0] == 0) begin
        int p;
        p = q_pin[0];
        if (q_obs[0] != q_exp[0]) begin
          r_sticky[p] = 1; r_live[p] = 1;
          if (r_cnt[p] < 255) r_cnt[p]++;
        end else begin
          r_live[p] = 0;
        end
        void'(q_age.pop_front()); void'(q_pin.pop_front());
        void'(q_exp.pop_front()); void'(q_obs.pop_front());
      end
      if (ph % 2 == 1) begin
        q_age.push_back(2); q_pin.push_back(bit'(ph / 4));
        q_exp.push_back(bit'((ph / 2) % 2)); q_obs.push_back(rnet);
      end else begin
        if (!((ph / 4 == 1) ? open1 : open0)) rnet = bit'((ph / 2) % 2);
      end
      ph = (ph + 1) % 8;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison away from the edge
  always @(negedge clk) begin
    if (!done) begin
      bit e_oe0, e_oe1;
      e_oe0 = rst_n && en && (ph % 2 == 0) && (ph / 4 == 0);
      e_oe1 = rst_n && en && (ph % 2 == 0) && (ph / 4 == 1);
      chk(tp0_oe == e_oe0, "R3 R4 oe0", tp0_oe, e_oe0);
      chk(tp1_oe == e_oe1, "R3 R4 oe1", tp1_oe, e_oe1);
      if (e_oe0) chk(tp0_o == bit'((ph / 2) % 2), "R3 val0", tp0_o, (ph / 2) % 2);
      if (e_oe1) chk(tp1_o == bit'((ph / 2) % 2), "R3 val1", tp1_o, (ph / 2) % 2);
      chk(sticky == {r_sticky[1], r_sticky[0]}, "R7 sticky", sticky, {r_sticky[1], r_sticky[0]});
      chk(live == {r_live[1], r_live[0]}, "R8 live", live, {r_live[1], r_live[0]});
      chk(cnt0 == r_cnt[0], "R5 R6 R9 cnt0", cnt0, r_cnt[0]);
      chk(cnt1 == r_cnt[1], "R5 R6 R9 cnt1", cnt1, r_cnt[1]);
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] h0, h1;
    logic [1:0] hs, hl;
    step(3);
    // R1 reset state
    chk(sticky == 0 && live == 0, "R1 flags", {sticky, live}, 0);
    chk(cnt0 == 0 && cnt1 == 0, "R1 counters", {cnt0, cnt1}, 0);
    chk(!tp0_oe && !tp1_oe, "R1 pads", {tp1_oe, tp0_oe}, 0);
    rst_n = 1'b1; en = 1'b1;
    step(80);
    chk(sticky == 0, "R6 healthy", sticky, 0);
    // open on pad 0
    open0 = 1;
    step(48);
    chk(sticky[0] == 1, "R6 pad0 open", sticky[0], 1);
    chk(cnt1 == 0 && sticky[1] == 0, "R10 pad1 untouched", {sticky[1], cnt1}, 0);
    open0 = 0;
    step(24);
    chk(live[0] == 0, "R8 live clears", live[0], 0);
    chk(sticky[0] == 1, "R7 sticky holds", sticky[0], 1);
    // enable low: freeze
    open1 = 1;
    step(13);
    h0 = cnt0; h1 = cnt1; hs = sticky; hl = live;
    en = 1'b0;
    step(30);
    chk(cnt0 == h0 && cnt1 == h1, "R2 counters hold", {cnt1, cnt0}, {h1, h0});
    chk(sticky == hs && live == hl, "R2 flags hold", {sticky, live}, {hs, hl});
    // irregular enable with opens on both pads
    open0 = 1;
    for (int i = 0; i < 300; i++) begin
      en = ((i % 3) != 1) || ((i % 7) == 0);
      step(1);
    end
    en = 1'b1; open0 = 0;
    // saturate pad 1
    step(2200);
    chk(cnt1 == 8'd255, "R9 saturation", cnt1, 255);
    step(40);
    chk(cnt1 == 8'd255, "R9 no wrap", cnt1, 255);
    open1 = 0;
    step(24);
    chk(live[1] == 0 && sticky[1] == 1, "R8 R7 pad1 recovery", {live[1], sticky[1]}, 1);
    // reset mid-run
    @(posedge clk); #2 rst_n = 1'b0;
    step(2);
    chk(sticky == 0 && cnt1 == 0 && cnt0 == 0, "R1 R7 reset clears", {sticky, cnt1, cnt0}, 0);
    chk(!tp0_oe && !tp1_oe, "R1 pads float", {tp1_oe, tp0_oe}, 0);
    rst_n = 1'b1;
    step(40);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule